// File: doc/BRIEF.md
# Handshake Interrupt-Source Clearing Sequencer

This block works beside a data mover that runs in hardware handshake mode. Up to eleven slow peripherals each raise a trigger line when they hold data. When any trigger that is enabled asserts, the sequencer walks a bitmap of sources that must be cleared. For each marked source it issues one write, using that source's own programmed address and write value. A per-source select bit sends the write either to the system fabric or to the internal crossbar.

Writes go out one at a time. Each one is held until the fabric acknowledges it. After the last acknowledge the block pulses a done flag. While a sequence runs, the block reports a 4-bit multi-bit lock flag so that the surrounding configuration stays frozen. A trigger that arrives during a sequence is picked up again when the sequence ends. The peripheral is expected to drop its trigger on its own once its FIFO is drained, so nothing here clears the trigger line. Moving the data itself is not part of this block.

Top module: `hs_clear_seq`

## Requirements
- R1: After reset, wrReq and seqDone are 0 and lockFlag is 4'h6.
- R2: A sequence starts only when (trigIn & enMask) is non-zero while the block is idle. A trigger on a masked source, or an acknowledge while idle, produces no request, no done pulse and no change of lockFlag.
- R3: A sequence issues exactly one write for each bit n set in clrSel as captured at the start of the sequence, with wrAddr = entry n of addrTable and wrData = entry n of valTable (entry n occupies bits [n*32 +: 32]).
- R4: For source n, wrBus equals busSel[n]: 0 means the system fabric and 1 means the internal crossbar.
- R5: Selected sources are written in ascending index order.
- R6: wrReq stays asserted with wrAddr, wrData and wrBus stable until a cycle in which wrAck is 1. The next write, if any, appears in the following cycle.
- R7: seqDone is high for exactly one cycle: the cycle after the last write is acknowledged. If clrSel is empty, seqDone is high in the cycle after the trigger is taken and no write is issued.
- R8: lockFlag reads 4'h6 (unlocked) while idle and 4'h9 (locked) from the cycle after a trigger is taken through the seqDone cycle.
- R9: A trigger that is held high while a sequence runs starts a new sequence: its first write request appears two cycles after the seqDone cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 11 | Peripheral trigger lines |
| enMask | input | 11 | Per-source trigger enable |
| clrSel | input | 11 | Sources that get a clearing write |
| busSel | input | 11 | Per-source fabric select (1 = internal crossbar) |
| addrTable | input | 352 | Packed per-source write addresses, 32 bits each |
| valTable | input | 352 | Packed per-source write values, 32 bits each |
| wrAck | input | 1 | Write acknowledge from the fabric |
| wrReq | output | 1 | Clearing write request |
| wrAddr | output | 32 | Address of the current write |
| wrData | output | 32 | Value of the current write |
| wrBus | output | 1 | Fabric of the current write |
| seqDone | output | 1 | One-cycle pulse at the end of a sequence |
| lockFlag | output | 4 | Multi-bit lock flag, 4'h6 when unlocked |

## Verification
Random clear-select bitmaps with random tables and bus bits test the walk against a bench model of the lowest-set-bit order. Random acknowledge delays show that a request is held and does not advance early. Several directed patterns cover the edges. A single bit at index 0 and a single bit at index 10 test the bitmap ends. An empty bitmap must give an immediate done. A trigger on a masked source must be ignored. A trigger held through a running sequence must start a new sequence that begins at the predicted cycle.

// File: rtl/hs_clear_pkg.sv
package hs_clear_pkg;
  localparam int NUM_SRC = 11;
  localparam logic [3:0] LOCK_OPEN = 4'h6;
  localparam logic [3:0] LOCK_HELD = 4'h9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_DONE  = 2'd2
  } seqState_e;

  typedef struct packed {
    logic load;    // capture clrSel into the pending bitmap
    logic retire;  // drop the current source after its ack
  } seqStrobe_t;
endpackage

// File: rtl/hs_clear_ctrl.sv
module hs_clear_ctrl
  import hs_clear_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fireReq,
  input  logic       selEmpty,
  input  logic       lastWrite,
  input  logic       wrAck,
  output seqStrobe_t strb,
  output logic       wrReq,
  output logic       seqDone,
  output logic [3:0] lockFlag
);
  seqState_e state, stateNext;

  always_comb begin
    stateNext   = state;
    strb.load   = 1'b0;
    strb.retire = 1'b0;
    unique case (state)
      ST_IDLE: if (fireReq) begin
        strb.load = 1'b1;
        stateNext = selEmpty ? ST_DONE : ST_WRITE;
      end
      ST_WRITE: if (wrAck) begin
        strb.retire = 1'b1;
        if (lastWrite) stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign wrReq    = (state == ST_WRITE);
  assign seqDone  = (state == ST_DONE);
  assign lockFlag = (state == ST_IDLE) ? LOCK_OPEN : LOCK_HELD;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck) |=> wrReq);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);
  // R2
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrReq && !seqDone && !fireReq) |=> !wrReq && !seqDone);
endmodule

// File: rtl/hs_clear_dp.sv
module hs_clear_dp
  import hs_clear_pkg::*;
#(
  parameter int NSRC   = NUM_SRC,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strb,
  input  logic [NSRC-1:0]        trigIn,
  input  logic [NSRC-1:0]        enMask,
  input  logic [NSRC-1:0]        clrSel,
  input  logic [NSRC-1:0]        busSel,
  input  logic [NSRC*ADDR_W-1:0] addrTable,
  input  logic [NSRC*DATA_W-1:0] valTable,
  output logic                   fireReq,
  output logic                   selEmpty,
  output logic                   lastWrite,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [DATA_W-1:0]      wrData,
  output logic                   wrBus
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  pending;
  logic [NSRC-1:0]  curHot;
  logic [IDX_W-1:0] curIdx;

  assign fireReq   = |(trigIn & enMask);
  assign selEmpty  = (clrSel == '0);
  assign curHot    = pending & (~pending + NSRC'(1));
  assign lastWrite = ((pending & ~curHot) == '0);

  always_comb begin
    curIdx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) curIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pending <= '0;
    else if (strb.load)   pending <= clrSel;
    else if (strb.retire) pending <= pending & ~curHot;
  end

  assign wrAddr = addrTable[curIdx*ADDR_W +: ADDR_W];
  assign wrData = valTable[curIdx*DATA_W +: DATA_W];
  assign wrBus  = busSel[curIdx];

  // R3
  pend_shrink_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ((pending & ~$past(pending)) == '0));
  // R5
  asc_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.retire && !lastWrite) |=> (curIdx > $past(curIdx)));
  // R3
  single_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(curHot));
endmodule

// File: rtl/hs_clear_seq.sv
module hs_clear_seq
  import hs_clear_pkg::*;
#(
  parameter int NSRC   = NUM_SRC,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NSRC-1:0]        trigIn,
  input  logic [NSRC-1:0]        enMask,
  input  logic [NSRC-1:0]        clrSel,
  input  logic [NSRC-1:0]        busSel,
  input  logic [NSRC*ADDR_W-1:0] addrTable,
  input  logic [NSRC*DATA_W-1:0] valTable,
  input  logic                   wrAck,
  output logic                   wrReq,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [DATA_W-1:0]      wrData,
  output logic                   wrBus,
  output logic                   seqDone,
  output logic [3:0]             lockFlag
);
  seqStrobe_t strb;
  logic fireReq, selEmpty, lastWrite;

  hs_clear_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fireReq(fireReq), .selEmpty(selEmpty),
    .lastWrite(lastWrite), .wrAck(wrAck), .strb(strb), .wrReq(wrReq),
    .seqDone(seqDone), .lockFlag(lockFlag)
  );

  hs_clear_dp #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .trigIn(trigIn), .enMask(enMask),
    .clrSel(clrSel), .busSel(busSel), .addrTable(addrTable),
    .valTable(valTable), .fireReq(fireReq), .selEmpty(selEmpty),
    .lastWrite(lastWrite), .wrAddr(wrAddr), .wrData(wrData), .wrBus(wrBus)
  );

  // R6
  req_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck) |=> ($stable(wrAddr) && $stable(wrData) && $stable(wrBus)));
  // R8
  lock_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq || seqDone) |-> (lockFlag == LOCK_HELD));
endmodule

// File: tb/tb_hs_clear_seq.sv
module tb_hs_clear_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] trigIn = '0, enMask = '1, clrSel = '0, busSel = '0;
  logic [N*32-1:0] addrTable = '0, valTable = '0;
  logic wrAck = 1'b0;
  logic wrReq, wrBus, seqDone;
  logic [31:0] wrAddr, wrData;
  logic [3:0] lockFlag;

  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_clear_seq dut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .enMask(enMask), .clrSel(clrSel),
    .busSel(busSel), .addrTable(addrTable), .valTable(valTable), .wrAck(wrAck),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrBus(wrBus),
    .seqDone(seqDone), .lockFlag(lockFlag)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int lowIdx(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic fillTables();
    for (int i = 0; i < N; i++) begin
      addrTable[i*32 +: 32] = $urandom;
      valTable[i*32 +: 32]  = $urandom;
    end
  endtask

  // Walks the expected writes starting at the current negedge; ends at seqDone cycle.
  task automatic expectWrites(input bit randWait);
    logic [N-1:0] pend = clrSel;
    while (pend != '0) begin
      int idx = lowIdx(pend);
      int waits = randWait ? int'($urandom_range(0, 2)) : 0;
      chk(wrReq === 1'b1, "R3 wrReq", wrReq, 1);
      chk(wrAddr === addrTable[idx*32 +: 32], "R3/R5 wrAddr", wrAddr, addrTable[idx*32 +: 32]);
      chk(wrData === valTable[idx*32 +: 32], "R3 wrData", wrData, valTable[idx*32 +: 32]);
      chk(wrBus === busSel[idx], "R4 wrBus", wrBus, busSel[idx]);
      chk(lockFlag === 4'h9, "R8 lock busy", lockFlag, 4'h9);
      for (int w = 0; w < waits; w++) begin
        cyc();
        chk(wrReq === 1'b1 && wrAddr === addrTable[idx*32 +: 32] && wrBus === busSel[idx],
            "R6 hold", {wrReq, wrBus, wrAddr}, {1'b1, busSel[idx], addrTable[idx*32 +: 32]});
      end
      chk(seqDone === 1'b0, "R7 no early done", seqDone, 0);
      wrAck = 1'b1;
      cyc();
      wrAck = 1'b0;
      pend[idx] = 1'b0;
    end
    chk(seqDone === 1'b1 && wrReq === 1'b0, "R7 done", {wrReq, seqDone}, 2'b01);
    chk(lockFlag === 4'h9, "R8 lock at done", lockFlag, 4'h9);
  endtask

  task automatic startSeq(input logic [N-1:0] trig);
    trigIn = trig;
    cyc();
    trigIn = '0;
  endtask

  task automatic finishIdle();
    cyc();
    chk(seqDone === 1'b0 && wrReq === 1'b0, "R7 single pulse", {wrReq, seqDone}, 0);
    chk(lockFlag === 4'h6, "R8 lock idle", lockFlag, 4'h6);
  endtask

  task automatic checkQuiet(input string req);
    chk(wrReq === 1'b0 && seqDone === 1'b0 && lockFlag === 4'h6, req,
        {wrReq, seqDone, lockFlag}, {2'b00, 4'h6});
  endtask

  initial begin
    void'($urandom(32'h5EED_0B1E));
    repeat (3) @(negedge clk);
    checkQuiet("R1 reset state");
    rstN = 1'b1;
    cyc();
    checkQuiet("R1 after release");

    // R2: masked trigger and idle ack ignored
    fillTables();
    clrSel = 11'h005; enMask = 11'h7FE;
    startSeq(11'h001);
    checkQuiet("R2 masked trigger");
    cyc();
    checkQuiet("R2 masked trigger later");
    wrAck = 1'b1; cyc(); wrAck = 1'b0;
    checkQuiet("R2 idle ack");
    enMask = '0;
    startSeq('1);
    checkQuiet("R2 zero enable");

    // R7: empty clear mask gives immediate done
    enMask = 11'h7FF; clrSel = '0;
    startSeq(11'h100);
    chk(seqDone === 1'b1 && wrReq === 1'b0, "R7 empty mask done", {wrReq, seqDone}, 1);
    chk(lockFlag === 4'h9, "R8 lock empty", lockFlag, 4'h9);
    finishIdle();

    // R3/R4: single bit at the two ends
    clrSel = 11'h001; busSel = 11'h001;
    startSeq(11'h400);
    expectWrites(0);
    finishIdle();
    clrSel = 11'h400; busSel = 11'h000;
    startSeq(11'h001);
    expectWrites(0);
    finishIdle();

    // R5/R4: all sources, alternating bus
    clrSel = 11'h7FF; busSel = 11'h555;
    startSeq(11'h020);
    expectWrites(1);
    finishIdle();

    // R9: trigger held through a sequence is resampled after done
    clrSel = 11'h091; busSel = 11'h080;
    startSeq(11'h001);
    trigIn = 11'h008;
    expectWrites(0);
    cyc();
    chk(wrReq === 1'b0 && seqDone === 1'b0, "R9 idle gap", {wrReq, seqDone}, 0);
    cyc();
    trigIn = '0;
    chk(wrReq === 1'b1, "R9 resampled trigger", wrReq, 1);
    expectWrites(0);
    finishIdle();

    // Random mix
    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] t;
      fillTables();
      clrSel = N'($urandom); busSel = N'($urandom);
      enMask = N'($urandom); t = N'($urandom);
      startSeq(t);
      if ((t & enMask) == '0) begin
        checkQuiet("R2 random no fire");
      end else if (clrSel == '0) begin
        chk(seqDone === 1'b1, "R7 random empty", seqDone, 1);
        finishIdle();
      end else begin
        expectWrites(1);
        finishIdle();
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule